// File: doc/BRIEF.md
# Serial Security Register Reader

This block is the slave-side front end of a serial flash for one command: reading a fixed, read-only identification and security register over a mode-0 serial bus. The serial pins (serial clock, active-low select and data in) are oversampled by the chip clock through a short synchronizer. The block takes the command byte MSB first on rising serial-clock edges. After a good command it ignores three padding bytes. It then returns the register contents one bit per falling serial-clock edge, MSB first, starting at byte 0.

The register contents come from a parallel preload port that the surrounding chip writes while the bus is idle. Once every byte has been sent, more clock pulses return all-ones bits. A command byte the block does not recognise keeps the data output disabled until the select line goes high again. Raising the select line at any bit ends the transfer. It also clears every counter and drops the output enable. The block gives an output-enable signal for the pad and a flag that is high while a recognised command is being served.

Top module: `ssr_reader`

## Requirements
- R1: While `cs_n` is low, the block shifts in the first 8 bits, MSB first, on rising edges of `sck`. It accepts the command only if that byte equals 0x77. Any other value, including 0x76, 0xF7, 0x00 and 0xFF, is rejected.
- R2: After an accepted command byte, exactly 24 more bits are taken and their values are ignored. Bit 7 of register byte 0 is driven on the first falling `sck` edge after the 24th padding bit's rising edge.
- R3: Register bytes are sent in ascending index order from 0 to NBYTES-1, each MSB first. `so` changes only on falling `sck` edges.
- R4: Once NBYTES bytes have been sent, every further falling edge drives `so` to 1, and `so_oe` stays high.
- R5: When `cs_n` goes high at any bit, `so_oe` and `cmd_active` drop and the bit and byte counters clear. The next selection starts a new command from byte 0.
- R6: After a rejected command byte, `so_oe` and `cmd_active` stay low for any number of further `sck` pulses until `cs_n` goes high.
- R7: A cycle with `pl_we` high stores `pl_data` into register byte `pl_addr`. A later read returns that value.
- R8: `cmd_active` is high from the accepted command byte until `cs_n` goes high. `so_oe` is low during the command and padding bytes and high from the first data bit on.
- R9: While `rst_n` is low, `so_oe` and `cmd_active` are low.
- R10: `so`, `so_oe` and `cmd_active` respond within SYNC_STAGES+2 `clk` cycles of the `sck` or `cs_n` pin edge that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master, idle low |
| cs_n | input | 1 | Active-low select from the bus master |
| si | input | 1 | Serial data from the master |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | log2(NBYTES) | Preload byte index |
| pl_data | input | 8 | Preload byte value |
| so | output | 1 | Serial data toward the master; the pad drives it only when `so_oe` is high |
| so_oe | output | 1 | Pad output enable for `so`; low means high impedance |
| cmd_active | output | 1 | A recognised read command is in progress |

## Verification
Each serial pin edge passes through SYNC_STAGES flops and one edge-detect compare before a state register moves. So `so`, `so_oe` and `cmd_active` settle no later than SYNC_STAGES+2 chip-clock cycles after the pin edge. The bench holds each half of the serial clock for 8 chip cycles. It samples `so` at the end of the low half, just before the rising edge, where a real master would sample it. It checks the enable and the active flag 4 cycles after a select-line change. One directed check samples 4 cycles after the last padding bit's falling edge, to confirm that the first data bit arrives within the stated latency.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_DUMMY  = 2'd1,
    PH_DATA   = 2'd2,
    PH_REJECT = 2'd3
  } ph_t;

  localparam logic [7:0] RD_OPCODE  = 8'h77;
  localparam int         DUMMY_BITS = 24;
  localparam int         CMD_CNT_W  = 5;

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic si_s
);

  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] si_q;
  logic              sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      cs_q     <= '1;
      si_q     <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_q[0] <= sck_i;
      cs_q[0]  <= cs_n_i;
      si_q[0]  <= si_i;
      for (int i = 1; i < STAGES; i++) begin
        sck_q[i] <= sck_q[i-1];
        cs_q[i]  <= cs_q[i-1];
        si_q[i]  <= si_q[i-1];
      end
      sck_last <= sck_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_last;
  assign sck_fall = ~sck_q[STAGES-1] & sck_last;
  assign cs_idle  = cs_q[STAGES-1];
  assign si_s     = si_q[STAGES-1];

endmodule

// File: rtl/ssr_cmd_fsm.sv
module ssr_cmd_fsm
  import ssr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_idle,
  input  logic sck_rise,
  input  logic si_s,
  output ph_t  phase
);

  localparam logic [CMD_CNT_W-1:0] OPC_LAST = CMD_CNT_W'(7);
  localparam logic [CMD_CNT_W-1:0] DUM_LAST = CMD_CNT_W'(DUMMY_BITS - 1);

  ph_t                  ph_q, ph_d;
  logic [CMD_CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]           opc_q, opc_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    opc_d = opc_q;
    if (cs_idle) begin
      ph_d  = PH_OPCODE;
      cnt_d = '0;
      opc_d = '0;
    end else if (sck_rise) begin
      case (ph_q)
        PH_OPCODE: begin
          opc_d = {opc_q[6:0], si_s};
          if (cnt_q == OPC_LAST) begin
            cnt_d = '0;
            ph_d  = (opc_d == RD_OPCODE) ? PH_DUMMY : PH_REJECT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt_q == DUM_LAST) begin
            cnt_d = '0;
            ph_d  = PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OPCODE;
      cnt_q <= '0;
      opc_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      opc_q <= opc_d;
    end
  end

  assign phase = ph_q;

  // R1: padding phase is reached only from a complete 0x77 command byte
  p_opcode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DUMMY && $past(ph_q) == PH_OPCODE) |-> (opc_q == RD_OPCODE));

  // R2: padding counter never passes the last padding bit
  p_dummy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DUMMY) |-> (cnt_q <= DUM_LAST));

  // R6: a rejected command stays rejected while selected
  p_reject_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_REJECT && !cs_idle) |=> (ph_q == PH_REJECT));

  // R5: deselect clears the command state
  p_idle_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (ph_q == PH_OPCODE && cnt_q == '0));

endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
  parameter int NBYTES = 128,
  parameter int AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (pl_we) begin
      mem[pl_addr] <= pl_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R7: a preload write lands in the addressed byte
  p_preload_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pl_we |=> (mem[$past(pl_addr)] == $past(pl_data)));

endmodule

// File: rtl/ssr_tx.sv
module ssr_tx #(
  parameter int NBYTES = 128,
  parameter int AW     = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_idle,
  input  logic          sck_fall,
  input  logic          in_data,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          so,
  output logic          so_oe
);

  localparam int TOTAL = NBYTES * 8;
  localparam int SW    = $clog2(TOTAL + 1);
  localparam logic [SW-1:0] SENT_END = SW'(TOTAL);

  logic [SW-1:0] sent_q, sent_d;
  logic          so_q, so_d;
  logic          oe_q, oe_d;

  always_comb begin
    sent_d = sent_q;
    so_d   = so_q;
    oe_d   = oe_q;
    if (cs_idle) begin
      sent_d = '0;
      so_d   = 1'b0;
      oe_d   = 1'b0;
    end else if (sck_fall && in_data) begin
      oe_d = 1'b1;
      if (sent_q < SENT_END) begin
        so_d   = rd_data[3'd7 - sent_q[2:0]];
        sent_d = sent_q + 1'b1;
      end else begin
        so_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sent_q <= sent_d;
      so_q   <= so_d;
      oe_q   <= oe_d;
    end
  end

  assign rd_addr = sent_q[3 +: AW];
  assign so      = so_q;
  assign so_oe   = oe_q;

  // R3: the data line moves only on a falling serial edge
  p_so_falls_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_idle) |=> $stable(so_q));

  // R3: the bit counter never runs past the register end
  p_sent_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= SENT_END);

  // R4: past the end, ones are driven
  p_ones_when_spent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_q == SENT_END && sck_fall && in_data && !cs_idle) |=> so_q);

  // R5: deselect releases the pad
  p_oe_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !oe_q);

  // R8: the pad is enabled only in the data phase
  p_oe_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> in_data);

endmodule

// File: rtl/ssr_reader.sv
module ssr_reader
  import ssr_pkg::*;
#(
  parameter int NBYTES      = 128,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  output logic          so,
  output logic          so_oe,
  output logic          cmd_active
);

  logic          sck_rise, sck_fall, cs_idle, si_s;
  ph_t           phase;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          in_data;

  ssr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (sck),
    .cs_n_i   (cs_n),
    .si_i     (si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_idle  (cs_idle),
    .si_s     (si_s)
  );

  ssr_cmd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_idle  (cs_idle),
    .sck_rise (sck_rise),
    .si_s     (si_s),
    .phase    (phase)
  );

  ssr_store #(.NBYTES(NBYTES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .pl_we   (pl_we),
    .pl_addr (pl_addr),
    .pl_data (pl_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign in_data = (phase == PH_DATA);

  ssr_tx #(.NBYTES(NBYTES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_idle  (cs_idle),
    .sck_fall (sck_fall),
    .in_data  (in_data),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .so       (so),
    .so_oe    (so_oe)
  );

  assign cmd_active = (phase == PH_DUMMY) || (phase == PH_DATA);

  // R8: the pad is never enabled without an accepted command
  p_oe_needs_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> cmd_active);

  // R6: a rejected command never enables the pad
  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REJECT) |-> !so_oe);

endmodule

// File: tb/sim_ssr_reader.sv
module sim_ssr_reader;

  localparam int NB   = 128;
  localparam int HALF = 8;
  localparam int LAT  = 4;

  logic       clk = 1'b0;
  logic       rst_n, sck, cs_n, si, pl_we;
  logic [6:0] pl_addr;
  logic [7:0] pl_data;
  logic       so, so_oe, cmd_active;

  logic [7:0] shadow [NB];
  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  ssr_reader u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .so(so), .so_oe(so_oe), .cmd_active(cmd_active)
  );

  function automatic logic [7:0] exp_byte(input int k);
    return (k < NB) ? shadow[k] : 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    si = b;
    tick(HALF);
    r = so;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      logic r;
      spi_bit(tx[b], r);
      rx[b] = r;
    end
  endtask

  task automatic preload(input int a, input logic [7:0] d);
    pl_we = 1'b1; pl_addr = 7'(a); pl_data = d;
    tick(1);
    pl_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic deselect();
    tick(HALF);
    cs_n = 1'b1;
    tick(LAT);
    check(!so_oe, "R5 oe after deselect", so_oe, 0);
    check(!cmd_active, "R5 active after deselect", cmd_active, 0);
    tick(2*HALF);
  endtask

  task automatic start_read(input bit rnd_pad);
    logic [7:0] r;
    cs_n = 1'b0;
    tick(HALF);
    spi_byte(8'h77, r);
    check(cmd_active, "R8 active after opcode", cmd_active, 1);
    check(!so_oe, "R8 oe low in opcode/padding", so_oe, 0);
    for (int i = 0; i < 3; i++) spi_byte(rnd_pad ? 8'($urandom) : 8'h00, r);
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] r;
    for (int k = 0; k < n; k++) begin
      spi_byte(8'($urandom), r);
      check(r == exp_byte(k), (k < NB) ? req : "R4 ones past end", r, exp_byte(k));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic       rb;
    logic [7:0] bad [4];
    bad[0] = 8'h76; bad[1] = 8'hF7; bad[2] = 8'h00; bad[3] = 8'hFF;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    tick(3);
    check(!so_oe, "R9 reset oe", so_oe, 0);
    check(!cmd_active, "R9 reset active", cmd_active, 0);
    rst_n = 1'b1;
    tick(2);

    for (int a = 0; a < NB; a++) preload(a, 8'($urandom));

    // full read with exhaustion (R2, R3, R4, R7, R10)
    start_read(1'b0);
    tick(LAT);
    check(so_oe, "R10 oe within latency", so_oe, 1);
    check(so == shadow[0][7], "R2 first bit within latency", so, shadow[0][7]);
    read_bytes(NB + 3, "R7 R3 ascending bytes");
    check(so_oe, "R4 oe held past end", so_oe, 1);
    deselect();

    // random padding bytes are ignored (R2)
    start_read(1'b1);
    read_bytes(8, "R2 padding ignored");
    deselect();

    // rejected opcodes (R1, R6)
    for (int t = 0; t < 6; t++) begin
      logic [7:0] op;
      op = (t < 4) ? bad[t] : 8'($urandom);
      if (op == 8'h77) op = 8'h37;
      cs_n = 1'b0;
      tick(HALF);
      spi_byte(op, r);
      check(!cmd_active, "R1 wrong opcode rejected", cmd_active, 0);
      for (int i = 0; i < 4; i++) begin
        spi_byte(8'($urandom), r);
        check(!so_oe, "R6 oe stays low", so_oe, 0);
        check(!cmd_active, "R6 active stays low", cmd_active, 0);
      end
      deselect();
    end
    start_read(1'b1);
    read_bytes(2, "R5 recovery after reject");
    deselect();

    // abort inside opcode (R5)
    cs_n = 1'b0; tick(HALF);
    for (int i = 0; i < 4; i++) spi_bit(1'b0, rb);
    deselect();
    start_read(1'b0);
    read_bytes(2, "R5 restart after opcode abort");
    deselect();

    // abort inside padding (R5)
    begin
      int k;
      k = 1 + int'($urandom % 23);
      cs_n = 1'b0; tick(HALF);
      spi_byte(8'h77, r);
      for (int i = 0; i < k; i++) spi_bit(1'($urandom), rb);
      deselect();
    end
    start_read(1'b1);
    read_bytes(3, "R5 restart after padding abort");
    deselect();

    // abort inside data (R5)
    start_read(1'b0);
    read_bytes(5, "R3 bytes before abort");
    for (int i = 0; i < 3; i++) spi_bit(1'b1, rb);
    deselect();
    start_read(1'b0);
    read_bytes(2, "R5 restart from byte 0");
    deselect();

    // random rewrites and read lengths (R7, R3)
    for (int it = 0; it < 6; it++) begin
      for (int j = 0; j < 10; j++) preload(int'($urandom % NB), 8'($urandom));
      start_read(1'b1);
      read_bytes(1 + int'($urandom % 24), "R7 rewritten contents");
      deselect();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule